// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This unit owns the status byte of a serial nonvolatile memory and decides whether a given byte may be programmed. It keeps four pieces of state:

- a write-enable latch;
- a two-bit protection level that covers none, the top quarter, the top half or the whole array;
- a hardware-lock enable bit;
- a staged status update that waits for the end of the current selection.

An active-low lock pin is brought into the system clock through two flops. When that pin is low and the lock enable bit is set, the status byte cannot be rewritten.

The command front end uses several inputs. It pulses set and clear requests for the latch. It offers a status byte while the device is selected, and it reports the selection level; the staged update is committed when the selection ends. The programming controller reports busy and a completion pulse.

The unit returns the status byte at all times, and reads all ones while a programming cycle runs. It also gives a combinational verdict on whether a supplied byte address is writable.

Top module: `status_protect_unit`

## Requirements
- R1: After reset the status byte reads 0x00 and no address is reported writable.
- R2: When not busy, the status byte is: bit 7 lock enable, bits 6..4 zero, bit 3 and bit 2 the protection level (bit 3 high), bit 1 the write-enable latch, bit 0 zero.
- R3: While the busy input is high the status byte reads 0xFF.
- R4: A set request raises the latch. A clear request drops it whatever the lock pin level. A completion pulse drops it. When a completion pulse and a set request fall in one cycle, the latch ends cleared.
- R5: While busy, set requests, clear requests and status-write offers are ignored.
- R6: A status-write offer is accepted only while the latch is set. It changes only bits 7, 3 and 2, and it takes effect on the clock edge after the selection input falls.
- R7: While the synchronised lock pin is low and the lock enable bit is 1, status-write offers are refused, including one that clears the lock enable bit.
- R8: An accepted offer is cancelled if the lock condition becomes true while still selected. A lock that arrives after the selection has ended does not undo the committed update.
- R9: The lock pin passes through a two-flop synchroniser. A pin fall in the cycle of an offer does not refuse that offer.
- R10: An address is writable only when the latch is set, busy is low and the address is outside the protected range. For a 13-bit address the ranges are: level 01 covers 0x1800..0x1FFF, level 10 covers 0x1000..0x1FFF, level 11 covers the whole array, and level 00 covers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_pin_n | input | 1 | Asynchronous active-low hardware lock pin |
| sel_i | input | 1 | High while the device is selected |
| wel_set_i | input | 1 | Pulse: set the write-enable latch |
| wel_clr_i | input | 1 | Pulse: clear the write-enable latch |
| sr_load_i | input | 1 | Pulse: offer a status byte |
| sr_data_i | input | 8 | Offered status byte |
| busy_i | input | 1 | Programming cycle in progress |
| done_i | input | 1 | Pulse: programming cycle completed |
| chk_addr_i | input | ADDR_W | Byte address to judge |
| status_o | output | 8 | Current status byte |
| chk_ok_o | output | 1 | The judged address may be programmed |

## Verification
A completion pulse and a set request can arrive in the same cycle when the controller drops busy together with its done pulse. The bench drives both pulses at once with busy low and expects the latch to end cleared.

A lock-pin fall can also coincide with a status-write offer. The bench applies both at the same edge and expects the offer to be committed, because the synchronised pin still shows the old level.

// File: rtl/spu_pkg.sv
package spu_pkg;
    localparam int SR_W     = 8;
    localparam int POS_WEL  = 1;
    localparam int POS_LVL0 = 2;
    localparam int POS_LVL1 = 3;
    localparam int POS_HPE  = 7;

    typedef enum logic [1:0] {
        PROT_NONE    = 2'b00,
        PROT_QUARTER = 2'b01,
        PROT_HALF    = 2'b10,
        PROT_ALL     = 2'b11
    } prot_lvl_e;

    typedef struct packed {
        logic      wel;
        prot_lvl_e lvl;
        logic      hpe;
        logic      pend;
        logic [2:0] pbits;
        logic      sel;
    } sr_state_t;
endpackage

// File: rtl/spu_pin_sync.sv
module spu_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_o
);
    logic [STAGES-1:0] stg_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[i] <= 1'b1;
                end else if (i == 0) begin
                    stg_q[i] <= pin_i;
                end else begin
                    stg_q[i] <= stg_q[(i > 0) ? i-1 : 0];
                end
            end
        end
    endgenerate

    assign pin_o = stg_q[STAGES-1];
endmodule

// File: rtl/spu_status_core.sv
module spu_status_core
    import spu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_i,
    input  logic            pin_sync_i,
    input  logic            busy_i,
    input  logic            done_i,
    input  logic            set_i,
    input  logic            clr_i,
    input  logic            load_i,
    input  logic [SR_W-1:0] data_i,
    output logic [SR_W-1:0] status_o,
    output logic            wel_o,
    output prot_lvl_e       lvl_o
);
    sr_state_t s_d, s_q;
    logic      hw_lock;
    logic      commit;
    logic      unused_bits;

    assign unused_bits = ^{data_i[6:4], data_i[1:0]};

    always_comb begin
        s_d     = s_q;
        hw_lock = !pin_sync_i && s_q.hpe;
        commit  = s_q.sel && !sel_i;
        s_d.sel = sel_i;

        if (!busy_i) begin
            if (set_i) s_d.wel = 1'b1;
            if (clr_i) s_d.wel = 1'b0;
        end
        if (done_i) s_d.wel = 1'b0;

        if (commit && s_q.pend) begin
            s_d.hpe  = s_q.pbits[2];
            s_d.lvl  = prot_lvl_e'(s_q.pbits[1:0]);
            s_d.pend = 1'b0;
        end

        if (s_q.pend && sel_i && hw_lock) s_d.pend = 1'b0;

        if (!busy_i && load_i && s_q.wel && !hw_lock) begin
            s_d.pend  = 1'b1;
            s_d.pbits = {data_i[POS_HPE], data_i[POS_LVL1], data_i[POS_LVL0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{wel: 1'b0, lvl: PROT_NONE, hpe: 1'b0, pend: 1'b0,
                     pbits: 3'b000, sel: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (busy_i) begin
            status_o = '1;
        end else begin
            status_o          = '0;
            status_o[POS_HPE] = s_q.hpe;
            status_o[POS_LVL1:POS_LVL0] = s_q.lvl;
            status_o[POS_WEL] = s_q.wel;
        end
    end

    assign wel_o = s_q.wel;
    assign lvl_o = s_q.lvl;

    AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !s_q.wel); // R4
    AST_BUSY_FREEZES_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !done_i) |=> $stable(s_q.wel)); // R5
    AST_NO_WEL_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.wel && !s_q.pend) |=> ($stable(s_q.hpe) && $stable(s_q.lvl))); // R6
    AST_LOCK_REFUSES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && hw_lock && !s_q.pend) |=> !s_q.pend); // R7
    AST_LOCK_CANCELS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && sel_i && hw_lock) |=> !s_q.pend); // R8
endmodule

// File: rtl/spu_addr_gate.sv
module spu_addr_gate
    import spu_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  prot_lvl_e         lvl_i,
    input  logic              wel_i,
    input  logic              busy_i,
    output logic              ok_o
);
    localparam int HI = ADDR_W - 1;
    logic in_quarter;
    logic in_half;
    logic prot;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign in_quarter = &addr_i[HI -: 2];
        end else begin : g_narrow
            assign in_quarter = addr_i[HI];
        end
    endgenerate

    assign in_half = addr_i[HI];

    always_comb begin
        unique case (lvl_i)
            PROT_NONE:    prot = 1'b0;
            PROT_QUARTER: prot = in_quarter;
            PROT_HALF:    prot = in_half;
            default:      prot = 1'b1;
        endcase
    end

    assign ok_o = wel_i && !busy_i && !prot;
endmodule

// File: rtl/status_protect_unit.sv
module status_protect_unit
    import spu_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_pin_n,
    input  logic              sel_i,
    input  logic              wel_set_i,
    input  logic              wel_clr_i,
    input  logic              sr_load_i,
    input  logic [7:0]        sr_data_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [ADDR_W-1:0] chk_addr_i,
    output logic [7:0]        status_o,
    output logic              chk_ok_o
);
    logic      pin_sync;
    logic      wel;
    prot_lvl_e lvl;

    spu_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (lock_pin_n),
        .pin_o (pin_sync)
    );

    spu_status_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_i),
        .pin_sync_i (pin_sync),
        .busy_i     (busy_i),
        .done_i     (done_i),
        .set_i      (wel_set_i),
        .clr_i      (wel_clr_i),
        .load_i     (sr_load_i),
        .data_i     (sr_data_i),
        .status_o   (status_o),
        .wel_o      (wel),
        .lvl_o      (lvl)
    );

    spu_addr_gate #(.ADDR_W(ADDR_W)) u_gate (
        .addr_i (chk_addr_i),
        .lvl_i  (lvl),
        .wel_i  (wel),
        .busy_i (busy_i),
        .ok_o   (chk_ok_o)
    );

    AST_FULL_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3:2] == 2'b11 && !busy_i) |-> !chk_ok_o); // R10
    AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (!chk_ok_o && status_o[0])); // R3
endmodule

// File: tb/status_protect_unit_tb_top.sv
module status_protect_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_n = 1'b1;
    logic        sel = 1'b0;
    logic        wset = 1'b0;
    logic        wclr = 1'b0;
    logic        load = 1'b0;
    logic [7:0]  data = 8'h00;
    logic        busy = 1'b0;
    logic        done = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  status;
    logic        ok;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    status_protect_unit dut_i (
        .clk(clk), .rst_n(rst_n), .lock_pin_n(lock_n), .sel_i(sel),
        .wel_set_i(wset), .wel_clr_i(wclr), .sr_load_i(load), .sr_data_i(data),
        .busy_i(busy), .done_i(done), .chk_addr_i(addr),
        .status_o(status), .chk_ok_o(ok)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic chk_st(input string tag, input logic [7:0] exp);
        checks++;
        if (status !== exp) begin
            errors++;
            $display("FAIL %s status act=%h exp=%h", tag, status, exp);
        end
    endtask

    task automatic chk_ok(input string tag, input logic [12:0] a, input logic exp);
        addr = a;
        #1;
        checks++;
        if (ok !== exp) begin
            errors++;
            $display("FAIL %s ok addr=%h act=%b exp=%b", tag, a, ok, exp);
        end
    endtask

    task automatic pulse_set();
        wset = 1'b1; tick(); wset = 1'b0;
    endtask

    task automatic pulse_clr();
        wclr = 1'b1; tick(); wclr = 1'b0;
    endtask

    task automatic sr_write(input logic [7:0] d);
        sel = 1'b1; load = 1'b1; data = d;
        tick();
        load = 1'b0;
        tick();
        sel = 1'b0;
        tick();
    endtask

    function automatic logic exp_ok(input logic [12:0] a, input logic [1:0] l,
                                    input logic w, input logic b);
        logic p;
        case (l)
            2'b00:   p = 1'b0;
            2'b01:   p = (a[12:11] == 2'b11);
            2'b10:   p = a[12];
            default: p = 1'b1;
        endcase
        return w && !b && !p;
    endfunction

    initial begin
        void'($urandom(32'd20240613));
        @(negedge clk);
        ticks(2);
        rst_n = 1'b1;
        tick();

        chk_st("R1 reset", 8'h00);
        chk_ok("R1 reset", 13'h0000, 1'b0);

        pulse_set();
        chk_st("R4 set latch", 8'h02);
        chk_ok("R10 none level", 13'h1FFF, 1'b1);

        sr_write(8'hFF);
        chk_st("R6 R2 only bits 7,3,2", 8'h8E);
        chk_ok("R10 all level", 13'h0000, 1'b0);

        lock_n = 1'b0; ticks(3);
        pulse_clr();
        chk_st("R4 clear with pin low", 8'h8C);
        pulse_set();
        chk_st("R4 set with pin low", 8'h8E);
        sr_write(8'h00);
        chk_st("R7 locked write refused", 8'h8E);

        lock_n = 1'b1; ticks(3);
        sr_write(8'h04);
        chk_st("R6 write quarter", 8'h06);
        chk_ok("R10 quarter protected", 13'h1800, 1'b0);
        chk_ok("R10 quarter free", 13'h17FF, 1'b1);
        pulse_clr();
        sr_write(8'h08);
        chk_st("R6 no latch no write", 8'h04);
        pulse_set();
        sr_write(8'h84);
        chk_st("R6 set lock enable", 8'h86);

        sel = 1'b1; load = 1'b1; data = 8'h08;
        tick();
        load = 1'b0;
        lock_n = 1'b0;
        ticks(4);
        sel = 1'b0;
        tick();
        chk_st("R8 cancel pending", 8'h86);
        lock_n = 1'b1; ticks(3);

        sr_write(8'h8C);
        lock_n = 1'b0; ticks(3);
        chk_st("R8 committed stays", 8'h8E);
        lock_n = 1'b1; ticks(3);

        sel = 1'b1; lock_n = 1'b0; load = 1'b1; data = 8'h88;
        tick();
        load = 1'b0; sel = 1'b0;
        tick();
        chk_st("R9 synchroniser lag", 8'h8A);
        lock_n = 1'b1; ticks(3);

        busy = 1'b1; tick();
        chk_st("R3 busy all ones", 8'hFF);
        chk_ok("R10 busy blocks", 13'h0000, 1'b0);
        pulse_clr();
        busy = 1'b0; tick();
        chk_st("R5 clear ignored while busy", 8'h8A);
        busy = 1'b1;
        sr_write(8'h00);
        busy = 1'b0; tick();
        chk_st("R5 write ignored while busy", 8'h8A);

        wset = 1'b1; done = 1'b1;
        tick();
        wset = 1'b0; done = 1'b0;
        chk_st("R4 done beats set", 8'h88);
        chk_ok("R10 no latch", 13'h0000, 1'b0);

        for (int it = 0; it < 200; it++) begin
            logic [1:0] lv;
            logic       w;
            lv = 2'($urandom % 4);
            w  = 1'($urandom % 2);
            pulse_set();
            sr_write({4'b0000, lv, 2'b00});
            if (!w) pulse_clr();
            chk_st("R2 random level", {4'b0000, lv, w, 1'b0});
            for (int k = 0; k < 6; k++) begin
                logic [12:0] a;
                a = 13'($urandom);
                if (k == 0) a = 13'h1FFF;
                if (k == 1) a = 13'h0000;
                chk_ok("R10 random", a, exp_ok(a, lv, w, 1'b0));
            end
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule